// File: doc/BRIEF.md
# MMC Bus Width Test Unit

This unit carries out the data-line probe that a host uses to find out which DAT wires of a multimedia card actually work. The probe has two steps. In the send step the unit drives a short framed pattern on all eight data lines. In the return step it listens for the card's answer and grades each line.

In the send step every line carries a 0 start bit, a payload and a 1 end bit. Lines inside the selected width start their payload with a complementary two-bit pair. Lines outside the selected width carry zero payload. In the return step the unit waits for a start bit on DAT0. It then samples the next two bit times on every line and sets a pass bit for each active line whose pair came back inverted. Everything after those two bits, including any CRC, is ignored.

The command tokens that frame each step are issued by a separate command engine. That engine pulses the go strobe for the matching step and reads the done flag, the pass mask and the timeout flag.

Top module: `mmc_buswidth_tester`

## Requirements
- R1: While reset is asserted and after its release with no go strobe, `dat_oe`, `done`, `timeout` and `pass_mask` are all zero, and `dat_out` is zero.
- R2: A `tx_go` pulse accepted while idle makes all eight `dat_oe` bits high from the next cycle for exactly 2+8*PAT_BYTES cycles. The first of those cycles drives 0 on every line and the last drives 1 on every line. `dat_out` is zero whenever `dat_oe` is low.
- R3: The width code on `width_sel` selects the active lines: 0 means line 0 only, 1 means lines 0 to 3, 2 means all eight lines, and 3 is treated as 0.
- R4: In the payload of an active line, the first bit is 1 and the second is 0 for even line numbers. For odd line numbers the first bit is 0 and the second is 1. All later payload bits are 0.
- R5: Every payload bit of a line outside the selected width is 0.
- R6: `done` is a one-cycle pulse. It rises in the cycle after the end bit is driven, in the cycle after the second returned bit is sampled, or in the cycle after a timeout.
- R7: After an accepted `rx_go`, the first sampled cycle with `dat_in[0]` low is the start bit. The two following cycles are sampled as the first and second returned bit of each line.
- R8: A `pass_mask` bit is 1 only when its line is active, its first returned bit is the inverse of its first sent bit, and its second returned bit is the inverse of its second sent bit. Returned bits after the second one do not affect any output.
- R9: If `dat_in[0]` stays high for `tmo_limit` sampled cycles after the `rx_go` cycle, the unit sets `timeout`, clears `pass_mask` and pulses `done`. A limit of 0 acts as 1. A start bit seen in the last allowed cycle is accepted.
- R10: A go strobe that arrives while a step is running is ignored. If both strobes arrive together while idle, `tx_go` wins.
- R11: An accepted `rx_go` clears `timeout` and `pass_mask` in the next cycle. Otherwise both hold their value until the next step result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| width_sel | input | 2 | Bus width code: 0 = 1 line, 1 = 4 lines, 2 = 8 lines |
| tx_go | input | 1 | Starts the send step (one-cycle pulse) |
| rx_go | input | 1 | Starts the return step (one-cycle pulse) |
| tmo_limit | input | TMO_W | Maximum number of cycles to wait for the return start bit |
| dat_in | input | LANES | Sampled data line inputs |
| dat_out | output | LANES | Data line output values |
| dat_oe | output | LANES | Data line output enables |
| done | output | 1 | One-cycle step-complete pulse |
| timeout | output | 1 | Return start bit did not arrive in time |
| pass_mask | output | LANES | One bit per line, set when the line answered correctly |

## Verification
The checker takes for granted that go strobes last one cycle and that `width_sel` holds still while a step runs. The bench keeps to both rules. It only changes the width code while the unit is idle and raises each go strobe for a single cycle. The stimulus also drives go strobes into a running step, starts the return at the boundary of the timeout window, and applies a limit of zero. It feeds in a stuck line, and it sends tails full of low bits on DAT0 after the two graded bits.

// File: rtl/mmc_bt_pkg.sv
package mmc_bt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEND = 3'd1,
    ST_WAIT = 3'd2,
    ST_CAP0 = 3'd3,
    ST_CAP1 = 3'd4
  } bt_state_t;

  // number of lines taking part in the probe for a width code
  function automatic int unsigned active_lines(input logic [1:0] code);
    case (code)
      2'd1:    active_lines = 4;
      2'd2:    active_lines = 8;
      default: active_lines = 1;
    endcase
  endfunction

  // leading payload bit idx (0 or 1) of an active line
  function automatic logic lead_bit(input int unsigned line, input int unsigned idx);
    if (idx == 0)      lead_bit = (line % 2 == 0);
    else if (idx == 1) lead_bit = (line % 2 == 1);
    else               lead_bit = 1'b0;
  endfunction

endpackage

// File: rtl/mmc_bt_pattern_gen.sv
module mmc_bt_pattern_gen
  import mmc_bt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PAY   = 16,
  parameter int CW    = 5
) (
  input  logic [1:0]       width_sel,
  input  logic [CW-1:0]    bit_idx,
  output logic [LANES-1:0] lane_bits
);

  localparam logic [CW-1:0] END_IDX = CW'(PAY + 1);

  for (genvar g = 0; g < LANES; g++) begin : g_line
    logic active;
    assign active = (int'(g) < int'(active_lines(width_sel)));

    always_comb begin
      if (bit_idx == '0) begin
        lane_bits[g] = 1'b0;
      end else if (bit_idx == END_IDX) begin
        lane_bits[g] = 1'b1;
      end else begin
        lane_bits[g] = active &&
                       lead_bit(unsigned'(g), unsigned'(int'(bit_idx) - 1));
      end
    end
  end

endmodule

// File: rtl/mmc_bt_lane_check.sv
module mmc_bt_lane_check
  import mmc_bt_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [1:0]       width_sel,
  input  logic [LANES-1:0] first_bits,
  input  logic [LANES-1:0] second_bits,
  output logic [LANES-1:0] lane_ok
);

  for (genvar g = 0; g < LANES; g++) begin : g_line
    logic active;
    assign active = (int'(g) < int'(active_lines(width_sel)));
    assign lane_ok[g] = active &&
                        (first_bits[g]  == !lead_bit(unsigned'(g), 0)) &&
                        (second_bits[g] == !lead_bit(unsigned'(g), 1));
  end

endmodule

// File: rtl/mmc_buswidth_tester.sv
module mmc_buswidth_tester
  import mmc_bt_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int PAT_BYTES = 2,
  parameter int TMO_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       width_sel,
  input  logic             tx_go,
  input  logic             rx_go,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [LANES-1:0] dat_in,
  output logic [LANES-1:0] dat_out,
  output logic [LANES-1:0] dat_oe,
  output logic             done,
  output logic             timeout,
  output logic [LANES-1:0] pass_mask
);

  localparam int PAY      = 8 * PAT_BYTES;
  localparam int SEND_LEN = PAY + 2;
  localparam int CW       = $clog2(SEND_LEN + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(SEND_LEN - 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic rst_s1, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_i_n <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_i_n <= rst_s1;
    end
  end

  bt_state_t        state_q, state_d;
  logic [CW-1:0]    idx_q, idx_d;
  logic [TMO_W-1:0] wcnt_q, wcnt_d;
  logic [LANES-1:0] first_q;
  logic             first_en;
  logic             done_d;
  logic             tmo_d;
  logic [LANES-1:0] pass_d;
  logic [LANES-1:0] send_bits;
  logic [LANES-1:0] lane_ok;
  logic             wait_last;

  mmc_bt_pattern_gen #(.LANES(LANES), .PAY(PAY), .CW(CW)) u_gen (
    .width_sel (width_sel),
    .bit_idx   (idx_q),
    .lane_bits (send_bits)
  );

  mmc_bt_lane_check #(.LANES(LANES)) u_chk (
    .width_sel   (width_sel),
    .first_bits  (first_q),
    .second_bits (dat_in),
    .lane_ok     (lane_ok)
  );

  assign wait_last = ({1'b0, wcnt_q} + 1'b1) >= {1'b0, tmo_limit};
  assign first_en  = (state_q == ST_CAP0);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wcnt_d  = wcnt_q;
    done_d  = 1'b0;
    tmo_d   = timeout;
    pass_d  = pass_mask;
    case (state_q)
      ST_IDLE: begin
        if (tx_go) begin
          state_d = ST_SEND;
          idx_d   = '0;
        end else if (rx_go) begin
          state_d = ST_WAIT;
          wcnt_d  = '0;
          tmo_d   = 1'b0;
          pass_d  = '0;
        end
      end
      ST_SEND: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (!dat_in[0]) begin
          state_d = ST_CAP0;
        end else if (wait_last) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
          pass_d  = '0;
          done_d  = 1'b1;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_CAP0: state_d = ST_CAP1;
      ST_CAP1: begin
        state_d = ST_IDLE;
        pass_d  = lane_ok;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      wcnt_q    <= '0;
      first_q   <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      pass_mask <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      wcnt_q    <= wcnt_d;
      done      <= done_d;
      timeout   <= tmo_d;
      pass_mask <= pass_d;
      if (first_en) first_q <= dat_in;
    end
  end

  assign dat_oe  = {LANES{state_q == ST_SEND}};
  assign dat_out = (state_q == ST_SEND) ? send_bits : '0;

endmodule

// File: rtl/mmc_bt_checker.sv
module mmc_bt_checker #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_go,
  input logic [LANES-1:0] dat_out,
  input logic [LANES-1:0] dat_oe,
  input logic             done,
  input logic             timeout,
  input logic [LANES-1:0] pass_mask
);

  // R2: enables switch together for every line
  assert_oe_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe == '0) || (dat_oe == '1));

  // R2: idle lines carry zero
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe == '0) |-> (dat_out == '0));

  // R2: first driven cycle is the start bit on all lines
  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe[0]) |-> (dat_out == '0));

  // R2: last driven cycle is the end bit on all lines
  assert_end_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_oe[0]) |-> ($past(dat_out) == '1));

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a timeout never leaves a line marked good
  assert_tmo_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (pass_mask == '0));

  // R11: the mask only moves on a result or on a new return step
  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_mask) |-> (done || $past(rx_go)));

endmodule

bind mmc_buswidth_tester mmc_bt_checker #(.LANES(LANES)) u_bt_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_go     (rx_go),
  .dat_out   (dat_out),
  .dat_oe    (dat_oe),
  .done      (done),
  .timeout   (timeout),
  .pass_mask (pass_mask)
);

// File: tb/mmc_buswidth_tester_test.sv
`timescale 1ns/1ps
module mmc_buswidth_tester_test;

  localparam int LANES = 8;
  localparam int PAT_BYTES = 2;
  localparam int TMO_W = 16;
  localparam int PAY = 8 * PAT_BYTES;
  localparam int SEND_LEN = PAY + 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       width_sel;
  logic             tx_go, rx_go;
  logic [TMO_W-1:0] tmo_limit;
  logic [LANES-1:0] dat_in;
  logic [LANES-1:0] dat_out, dat_oe, pass_mask;
  logic             done, timeout;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mmc_buswidth_tester #(.LANES(LANES), .PAT_BYTES(PAT_BYTES), .TMO_W(TMO_W)) uut (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .tx_go(tx_go), .rx_go(rx_go),
    .tmo_limit(tmo_limit), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .done(done), .timeout(timeout), .pass_mask(pass_mask)
  );

  // ---------------- behavioural reference ----------------
  int  m_phase;   // 0 idle, 1 send, 2 await start, 3 first bit, 4 second bit
  int  m_pos;
  int  m_waited;
  bit  m_done, m_tmo;
  bit  m_pass [8];
  bit  m_first [8];

  function automatic int lines_for(input logic [1:0] w);
    if (w == 2'd1) return 4;
    if (w == 2'd2) return 8;
    return 1;
  endfunction

  function automatic bit expect_tx(input int line, input int pos, input logic [1:0] w);
    int p;
    if (pos == 0) return 1'b0;
    if (pos == SEND_LEN - 1) return 1'b1;
    p = pos - 1;
    if (line >= lines_for(w)) return 1'b0;
    if (p == 0) return (line % 2 == 0);
    if (p == 1) return (line % 2 == 1);
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pos = 0; m_waited = 0; m_done = 0; m_tmo = 0;
      for (int i = 0; i < 8; i++) begin m_pass[i] = 0; m_first[i] = 0; end
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (tx_go) begin m_phase = 1; m_pos = 0; end
        else if (rx_go) begin
          m_phase = 2; m_waited = 0; m_tmo = 0;
          for (int i = 0; i < 8; i++) m_pass[i] = 0;
        end
      end else if (m_phase == 1) begin
        if (m_pos == SEND_LEN - 1) begin m_phase = 0; m_done = 1; end
        else m_pos++;
      end else if (m_phase == 2) begin
        m_waited++;
        if (dat_in[0] == 1'b0) m_phase = 3;
        else if (m_waited >= ((tmo_limit == 0) ? 1 : int'(tmo_limit))) begin
          m_phase = 0; m_tmo = 1; m_done = 1;
          for (int i = 0; i < 8; i++) m_pass[i] = 0;
        end
      end else if (m_phase == 3) begin
        for (int i = 0; i < 8; i++) m_first[i] = dat_in[i];
        m_phase = 4;
      end else begin
        for (int i = 0; i < 8; i++)
          m_pass[i] = (i < lines_for(width_sel)) &&
                      (m_first[i] == ((i % 2 == 0) ? 1'b0 : 1'b1)) &&
                      (dat_in[i]  == ((i % 2 == 0) ? 1'b1 : 1'b0));
        m_phase = 0; m_done = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [7:0] e_out, e_oe, e_pass;
      e_oe = (m_phase == 1) ? 8'hFF : 8'h00;
      for (int i = 0; i < 8; i++) begin
        e_out[i]  = (m_phase == 1) ? expect_tx(i, m_pos, width_sel) : 1'b0;
        e_pass[i] = m_pass[i];
      end
      check(dat_oe == e_oe, "R2", "dat_oe", dat_oe, e_oe);
      check(dat_out == e_out, "R4/R5", "dat_out", dat_out, e_out);
      check(done == m_done, "R6", "done", done, m_done);
      check(timeout == m_tmo, "R9", "timeout", timeout, m_tmo);
      check(pass_mask == e_pass, "R8", "pass_mask", pass_mask, e_pass);
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse_tx();
    @(negedge clk); tx_go = 1'b1;
    @(negedge clk); tx_go = 1'b0;
    repeat (SEND_LEN + 3) @(negedge clk);
  endtask

  task automatic card_reply(input int delay, input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk); rx_go = 1'b1; dat_in = 8'hFF;
    @(negedge clk); rx_go = 1'b0;
    repeat (delay) begin dat_in = 8'hFF; @(negedge clk); end
    dat_in = 8'h00; @(negedge clk);
    dat_in = b0; @(negedge clk);
    dat_in = b1; @(negedge clk);
    for (int i = 0; i < 62; i++) begin dat_in = 8'(i * 37 + 4); @(negedge clk); end
    dat_in = 8'hFF; repeat (4) @(negedge clk);
  endtask

  task automatic no_reply(input int cycles);
    @(negedge clk); rx_go = 1'b1; dat_in = 8'hFF;
    @(negedge clk); rx_go = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; width_sel = 2'd2; tx_go = 0; rx_go = 0;
    tmo_limit = 16'd40; dat_in = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dat_oe == 0 && done == 0 && timeout == 0 && pass_mask == 0 && dat_out == 0,
          "R1", "reset outputs", {dat_oe, pass_mask}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dat_oe == 0 && pass_mask == 0, "R1", "after release", {dat_oe, pass_mask}, 0);

    // R2 R3 R4 R5: send step for each width code
    for (int w = 0; w < 4; w++) begin width_sel = 2'(w); pulse_tx(); end

    // R7 R8: all lines answer correctly in 8-line mode
    width_sel = 2'd2;
    card_reply(3, 8'hAA, 8'h55);
    check(pass_mask == 8'hFF, "R8", "8-line good", pass_mask, 8'hFF);
    // R3: 4-line mode only grades lines 0..3
    width_sel = 2'd1;
    card_reply(0, 8'hAA, 8'h55);
    check(pass_mask == 8'h0F, "R3", "4-line good", pass_mask, 8'h0F);
    // R3: 1-line mode
    width_sel = 2'd0;
    card_reply(5, 8'hAA, 8'h55);
    check(pass_mask == 8'h01, "R3", "1-line good", pass_mask, 8'h01);
    // R8: line 5 stuck low, line 2 not inverted
    width_sel = 2'd2;
    card_reply(2, 8'h8A, 8'h51);
    check(pass_mask == 8'hDB, "R8", "stuck lines", pass_mask, 8'hDB);

    // R9: timeout and boundary
    tmo_limit = 16'd20;
    no_reply(28);
    check(timeout == 1'b1 && pass_mask == 0, "R9", "timeout", {timeout, pass_mask}, 9'h100);
    card_reply(19, 8'hAA, 8'h55);
    check(timeout == 1'b0 && pass_mask == 8'hFF, "R9", "start in last slot",
          {timeout, pass_mask}, 9'h0FF);
    card_reply(20, 8'hAA, 8'h55);
    check(timeout == 1'b1 && pass_mask == 8'h00, "R9", "start one late",
          {timeout, pass_mask}, 9'h100);
    tmo_limit = 16'd0;
    no_reply(6);
    check(timeout == 1'b1, "R9", "zero limit", timeout, 1);
    tmo_limit = 16'd40;
    // R11: new rx_go clears timeout
    @(negedge clk); rx_go = 1'b1;
    @(negedge clk); rx_go = 1'b0;
    check(timeout == 1'b0 && pass_mask == 0, "R11", "clear on rx_go", timeout, 0);
    dat_in = 8'h00; @(negedge clk);
    dat_in = 8'hAA; @(negedge clk);
    dat_in = 8'h55; @(negedge clk);
    dat_in = 8'hFF; repeat (3) @(negedge clk);
    check(pass_mask == 8'hFF, "R7", "manual reply", pass_mask, 8'hFF);

    // R10: strobes while busy, and both at once
    @(negedge clk); tx_go = 1'b1; rx_go = 1'b1;
    @(negedge clk); tx_go = 1'b0; rx_go = 1'b0;
    check(dat_oe == 8'hFF, "R10", "tx wins", dat_oe, 8'hFF);
    repeat (3) @(negedge clk);
    rx_go = 1'b1; @(negedge clk); rx_go = 1'b0;
    tx_go = 1'b1; @(negedge clk); tx_go = 1'b0;
    repeat (SEND_LEN + 4) @(negedge clk);
    check(dat_oe == 0 && pass_mask == 8'hFF, "R10", "busy strobes ignored",
          {dat_oe, pass_mask}, 16'h00FF);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule